// File: doc/BRIEF.md
# ROM Byte-Sum Self-Test Engine

This engine checks a byte-wide ROM image through a synchronous read port whose data arrives one cycle after the request. A start pulse captures two runtime values: the image base address, and the offset of the last byte in the summed region. The same image can then be checked in whichever 2 KB slot it occupies. The engine reads the region one byte per cycle and keeps an 8-bit wrapping sum. It then reads the check byte that follows the region and compares that byte with the sum.

When the comparison finishes, the engine raises `done` for one cycle. The `pass` flag goes high if the check byte matched and stays at that value until the next accepted start. An offset of zero is a special case: the region is empty, the sum is zero, and the byte at the base itself is the check byte.

The controller has four states:
- `ST_IDLE`: waits for `start`. It goes to `ST_SUM`, or straight to `ST_CHK_RD` when the offset is zero.
- `ST_SUM`: issues one read per cycle. It goes to `ST_CHK_RD` once the read at the last offset has been issued.
- `ST_CHK_RD`: issues the check-byte read while the final summed byte is added. It always goes to `ST_CHK_WAIT`.
- `ST_CHK_WAIT`: compares the check byte with the sum and returns to `ST_IDLE`.

Top module: `rom_sum_checker`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `mem_rd` are all low.
- R2: For a start with offset L > 0, the engine issues reads at base+0, base+1, …, base+L and then base+L+1, one per cycle, with `mem_rd` high for each. All addresses are computed modulo 2^16.
- R3: `pass` is 1 exactly when the check byte at base+L+1 equals the low 8 bits of the sum of the bytes at base+0 through base+L.
- R4: With offset 0 the engine issues a single read at base+0, and `pass` is 1 exactly when that byte is 0x00.
- R5: `done` is a one-cycle pulse. It rises L+3 clock edges after the edge that accepts start (2 edges when L = 0). `busy` is high from the accepting edge until `done` rises, and is low while `done` is high.
- R6: An accepted start clears `pass`. After `done`, `pass` keeps its value until the next accepted start.
- R7: A start asserted while `busy` is high is ignored. The read sequence, the timing of `done` and the result are unchanged.
- R8: Any 16-bit base is accepted, including one where the check byte address wraps past 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a check |
| base_addr | input | 16 | Image base address, captured on start |
| last_offset | input | 11 | Offset of the last summed byte; 0 means empty region |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read request; data is due on `mem_rdata` in the next cycle |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last completed check |

## Verification
Each check in the bench runs on a cycle count taken from the edge that accepted start. Read requests are due one per cycle from the first cycle after that edge, and `done` with its `pass` value is due after exactly L+3 edges (2 when L is 0). Outputs are sampled on the falling edge, so every sample sees the settled result of the preceding rising edge. The checks of `pass` holding and of an ignored start are made a fixed number of cycles after `done` or after the injected pulse.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SUM,
        ST_CHK_RD,
        ST_CHK_WAIT
    } rsc_state_e;
endpackage

// File: rtl/rsc_addr_seq.sv
module rsc_addr_seq #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [OFS_W-1:0]  last_in,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    // one spare bit so that last+1 reaches the check byte at offset 0x800
    localparam int CNT_W = OFS_W + 1;

    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0]  last_q;
    logic [CNT_W-1:0]  ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            last_q <= '0;
            ofs_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            last_q <= last_in;
            ofs_q  <= '0;
        end else if (advance) begin
            ofs_q  <= ofs_q + 1'b1;
        end
    end

    // after the last summed offset the counter naturally points at the check byte
    assign addr    = base_q + ADDR_W'(ofs_q);
    assign at_last = (ofs_q == {1'b0, last_q});
endmodule

// File: rtl/rsc_accum.sv
module rsc_accum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sum_issue,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] sum
);
    logic              vld_q;
    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            acc_q <= '0;
        end else begin
            vld_q <= sum_issue;
            if (clear)
                acc_q <= '0;
            else if (vld_q)
                acc_q <= acc_q + rdata;
        end
    end

    assign sum = acc_q;
endmodule

// File: rtl/rom_sum_checker.sv
module rom_sum_checker
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFS_W-1:0]  last_offset,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass
);
    rsc_state_e        state_q, state_d;
    logic              accept;
    logic              at_last;
    logic [DATA_W-1:0] sum;

    assign accept = (state_q == ST_IDLE) && start;

    rsc_addr_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (state_q == ST_SUM),
        .base_in (base_addr),
        .last_in (last_offset),
        .addr    (mem_addr),
        .at_last (at_last)
    );

    rsc_accum #(.DATA_W(DATA_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sum_issue (state_q == ST_SUM),
        .rdata     (mem_rdata),
        .sum       (sum)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = (last_offset == '0) ? ST_CHK_RD : ST_SUM;
            ST_SUM:      if (at_last) state_d = ST_CHK_RD;
            ST_CHK_RD:   state_d = ST_CHK_WAIT;
            ST_CHK_WAIT: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else begin
            done <= (state_q == ST_CHK_WAIT);
            if (accept)
                pass <= 1'b0;
            else if (state_q == ST_CHK_WAIT)
                pass <= (mem_rdata == sum);
        end
    end

    assign mem_rd = (state_q == ST_SUM) || (state_q == ST_CHK_RD);
    assign busy   = (state_q != ST_IDLE);

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r1_rd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
    a_r6_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(pass));
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && state_q == ST_SUM) |=> (mem_addr == $past(mem_addr) + 1'b1));
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && state_q != ST_CHK_WAIT) |=> busy);
endmodule

// File: tb/rom_sum_checker_bench.sv
module rom_sum_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [10:0] last_offset = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, pass;

    int total = 0;
    int bad = 0;
    logic [15:0] cur_chk_addr = '0;
    logic [7:0]  cur_chk_val = '0;

    always #5 clk = ~clk;

    rom_sum_checker u_rom_sum_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .last_offset(last_offset), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass)
    );

    function automatic logic [7:0] fill_byte(input logic [15:0] a);
        logic [15:0] t;
        t = (a * 16'd37) ^ (a >> 5);
        return t[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return (a == cur_chk_addr) ? cur_chk_val : fill_byte(a);
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= rom_byte(mem_addr);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] base;
        logic [10:0] last;
        logic        corrupt;
        logic        exp_pass;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{16'h8000, 11'h796, 1'b0, 1'b1},
        '{16'h8800, 11'h796, 1'b1, 1'b0},
        '{16'h0100, 11'h001, 1'b0, 1'b1},
        '{16'hF800, 11'h7FF, 1'b0, 1'b1},
        '{16'h1234, 11'h005, 1'b1, 1'b0},
        '{16'h4000, 11'h000, 1'b0, 1'b1}
    };

    task automatic run_case(input logic [15:0] b, input logic [10:0] l,
                            input logic corrupt, input logic exp_pass, input logic poke);
        logic [7:0] s;
        int rd_cnt, rd_err, busy_err, lat, exp_lat, exp_rds;
        s = '0;
        if (l != 0) for (int i = 0; i <= int'(l); i++) s += fill_byte(b + 16'(i));
        cur_chk_addr = (l == 0) ? b : b + 16'(l) + 16'd1;
        cur_chk_val  = s + {7'd0, corrupt};
        exp_lat = (l == 0) ? 2 : int'(l) + 3;
        exp_rds = (l == 0) ? 1 : int'(l) + 2;
        rd_cnt = 0; rd_err = 0; busy_err = 0; lat = -1;
        @(negedge clk);
        base_addr = b; last_offset = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 pass cleared on start", pass, 0);
        for (int n = 0; n < 5000; n++) begin
            if (n > 0) @(negedge clk);
            if (poke && n == 3) begin start = 1'b1; base_addr = 16'hAAAA; last_offset = 11'd2; end
            if (poke && n == 4) start = 1'b0;
            if (done) begin lat = n; break; end
            if (!busy) busy_err++;
            if (mem_rd) begin
                if (mem_addr !== b + 16'(rd_cnt)) rd_err++;
                rd_cnt++;
            end
        end
        if (lat < 0) $display("watchdog: case did not finish");
        check(l == 0 ? "R4 read addresses" : "R2 read addresses", rd_err, 0);
        check("R2 read count", rd_cnt, exp_rds);
        check("R5 busy during run", busy_err, 0);
        check(poke ? "R7 latency with ignored start" : "R5 done latency", lat, exp_lat);
        check(l == 0 ? "R4 pass" : (b > 16'hF000 ? "R8 pass" : "R3 pass"), pass, exp_pass);
        @(negedge clk);
        check("R5 done one cycle", done, 0);
        repeat (4) @(negedge clk);
        check("R6 pass held", pass, exp_pass);
        check("R7 no extra activity", {busy, mem_rd, done}, 0);
    endtask

    initial begin
        #(10 * 190000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        check("R1 pass after reset", pass, 0);
        check("R1 mem_rd after reset", mem_rd, 0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++)
            run_case(VEC[k].base, VEC[k].last, VEC[k].corrupt, VEC[k].exp_pass, 1'b0);
        // R7: start pulse during a run is ignored
        run_case(16'h2000, 11'd20, 1'b0, 1'b1, 1'b1);
        // R4: empty region with non-zero byte at base fails
        run_case(16'h3000, 11'd0, 1'b1, 1'b0, 1'b0);
        // R8: check byte address wraps past 0xFFFF
        run_case(16'hFFF0, 11'h00F, 1'b1, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule